// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer with its registers on a simple memory-mapped bus. It has a bus address, a write strobe, write data and combinational read data. Software arms it by setting an enable bit and a 4-bit interval code. From then on, software must keep writing a fixed key word to the kick register. If it does not, the countdown reaches its end and the block either drives a system reset pulse or sets a sticky interrupt flag, depending on the action register.

The countdown is measured in half-second units. Each unit is one timebase tick, and a prescaler makes one tick every `PRESCALE` clock cycles. The interval code is not linear: the codes choose 0.5, 1, 2, 3, 4, 5, 6, 8, 10, 12, 14 or 16 seconds. After an expiry the countdown restarts by itself, so a watchdog that is never kicked fires periodically.

The parameter `VARIANT` picks one of two register layouts. The layouts differ in where the interval field sits and in how the expiry action is encoded.

Top module: `kwdt_top`

## Requirements
- R1: A write to address 0 whose bits 12:0 equal 0x14AF is a kick. Bit 0 is set and the key 0xA57 sits in bits 12:1. A kick reloads the countdown, and the next expiry then comes a full interval after the kick. Bits 31:13 of that write are ignored.
- R2: A write to address 0 with any other value in bits 12:0 leaves the countdown and the outputs unchanged.
- R3: Bit 0 of the mode register (address 1) enables the watchdog. Writing 0 to the mode register stops it, and while it is stopped no expiry occurs.
- R4: The 4-bit interval code sits in mode bits 6:3 when `VARIANT`=0 and in bits 7:4 when `VARIANT`=1.
- R5: The interval is N timebase ticks, and expiry comes exactly N*`PRESCALE` cycles after a reload. N depends on the code: N=1 for code 0, N=2*code for codes 1 to 6, and N=4*code-12 for codes 7 to 11. Codes 12 to 15 give N=32, the same as code 11.
- R6: The countdown reloads with the newly selected interval when a mode write sets the enable bit while it was clear. It also reloads when a mode write with the enable bit set changes the interval code.
- R7: With `VARIANT`=0, action register (address 2) bit 1 set makes expiry drive the system reset pulse. With that bit clear, expiry sets the interrupt flag instead.
- R8: With `VARIANT`=1, expiry drives the system reset only when action bits 1:0 equal 01. The values 00, 10 and 11 set the interrupt flag instead.
- R9: The interrupt flag is sticky. A kick clears it, and stopping the watchdog does not.
- R10: The system reset output stays high for exactly `RST_CYCLES` clock cycles after an expiry. The countdown restarts on its own, so a second expiry comes one interval after the first.
- R11: After reset, both outputs are low and the mode and action registers read 0. Reading address 1 or 2 returns the last word written there. Reading address 0 or 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Word select: 0 kick, 1 mode, 2 action, 3 unused |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sys_rst_out | output | 1 | System reset pulse on expiry |
| irq_out | output | 1 | Sticky expiry interrupt flag |

## Verification
Every expiry is timed to the exact cycle after the arming write. This separates the twelve interval lengths, and it shows that codes above 11 fall back to the longest interval. Two interrupted countdowns are compared against each other. A wrong-key kick must leave the original expiry cycle in place, while a correct kick with junk in the upper bits must push the expiry out by a whole interval. The two layouts are driven side by side. All four action encodings are tried on the second layout. A word that places the code at the first layout's field position must yield a different interval on the second layout. Random mixes of layout, code and action then confirm that the interval length and the choice between reset and interrupt agree with table functions in the bench.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int DATA_W = 32;
  localparam int IVL_W  = 6;
  localparam logic [12:0] KICK_WORD = 13'h14AF;

  typedef enum logic [1:0] {
    SEL_KICK   = 2'd0,
    SEL_MODE   = 2'd1,
    SEL_ACTION = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;

  // interval length in half-second ticks for a 4-bit code
  function automatic logic [IVL_W-1:0] interval_ticks(input logic [3:0] code);
    logic [IVL_W-1:0] n;
    case (code)
      4'd0:    n = 6'd1;
      4'd1:    n = 6'd2;
      4'd2:    n = 6'd4;
      4'd3:    n = 6'd6;
      4'd4:    n = 6'd8;
      4'd5:    n = 6'd10;
      4'd6:    n = 6'd12;
      4'd7:    n = 6'd16;
      4'd8:    n = 6'd20;
      4'd9:    n = 6'd24;
      4'd10:   n = 6'd28;
      default: n = 6'd32;
    endcase
    return n;
  endfunction

  function automatic int code_lsb(input int variant);
    return (variant == 0) ? 3 : 4;
  endfunction
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              enabled,
  output logic              act_reset,
  output logic              kick,
  output logic              reload,
  output logic [IVL_W-1:0]  ivl_now,
  output logic [IVL_W-1:0]  ivl_load
);
  localparam int LSB = code_lsb(VARIANT);

  logic [DATA_W-1:0] mode_q, action_q;
  logic              wr_mode, wr_action;
  logic [3:0]        code_q, code_w;

  assign wr_mode   = bus_wr && (bus_addr == SEL_MODE);
  assign wr_action = bus_wr && (bus_addr == SEL_ACTION);
  assign kick      = bus_wr && (bus_addr == SEL_KICK) && (bus_wdata[12:0] == KICK_WORD);

  assign code_q  = mode_q[LSB+3:LSB];
  assign code_w  = bus_wdata[LSB+3:LSB];
  assign enabled = mode_q[0];

  assign reload   = kick || (wr_mode && bus_wdata[0] && (!mode_q[0] || (code_w != code_q)));
  assign ivl_now  = interval_ticks(code_q);
  assign ivl_load = wr_mode ? interval_ticks(code_w) : ivl_now;

  generate
    if (VARIANT == 0) begin : g_act_bit
      assign act_reset = action_q[1];
    end else begin : g_act_field
      assign act_reset = (action_q[1:0] == 2'b01);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      action_q <= '0;
    end else begin
      if (wr_mode)   mode_q   <= bus_wdata;
      if (wr_action) action_q <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      SEL_MODE:   bus_rdata = mode_q;
      SEL_ACTION: bus_rdata = action_q;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/kwdt_timebase.sv
module kwdt_timebase #(
  parameter int PRESCALE = 12_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enabled,
  input  logic reload,
  output logic tick
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pcnt_q;

  assign tick = enabled && (pcnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pcnt_q <= '0;
    else if (reload || !enabled) pcnt_q <= '0;
    else if (tick)              pcnt_q <= '0;
    else                        pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
  import kwdt_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic             kick,
  input  logic             act_reset,
  input  logic [IVL_W-1:0] ivl_now,
  input  logic [IVL_W-1:0] ivl_load,
  output logic [IVL_W-1:0] cnt,
  output logic             expire,
  output logic             sys_rst,
  output logic             irq
);
  localparam int PW = $clog2(RST_CYCLES + 1);

  logic [PW-1:0] pulse_q;

  assign expire  = tick && (cnt == 6'd1) && !reload;
  assign sys_rst = (pulse_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= 6'd1;
      pulse_q <= '0;
      irq     <= 1'b0;
    end else begin
      if (reload)      cnt <= ivl_load;
      else if (expire) cnt <= ivl_now;
      else if (tick)   cnt <= cnt - 1'b1;

      if (expire && act_reset) pulse_q <= PW'(RST_CYCLES);
      else if (pulse_q != '0)  pulse_q <= pulse_q - 1'b1;

      if (kick)                     irq <= 1'b0;
      else if (expire && !act_reset) irq <= 1'b1;
    end
  end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int VARIANT    = 0,
  parameter int PRESCALE   = 12_000_000,
  parameter int RST_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sys_rst_out,
  output logic        irq_out
);
  logic             en_w, act_reset_w, kick_w, reload_w, tick_w, expire_w;
  logic [IVL_W-1:0] ivl_now_w, ivl_load_w, cnt_w;

  kwdt_regs #(.VARIANT(VARIANT)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .enabled(en_w),
    .act_reset(act_reset_w), .kick(kick_w), .reload(reload_w),
    .ivl_now(ivl_now_w), .ivl_load(ivl_load_w)
  );

  kwdt_timebase #(.PRESCALE(PRESCALE)) u_timebase (
    .clk(clk), .rst_n(rst_n), .enabled(en_w), .reload(reload_w), .tick(tick_w)
  );

  kwdt_core #(.RST_CYCLES(RST_CYCLES)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .reload(reload_w), .kick(kick_w),
    .act_reset(act_reset_w), .ivl_now(ivl_now_w), .ivl_load(ivl_load_w),
    .cnt(cnt_w), .expire(expire_w), .sys_rst(sys_rst_out), .irq(irq_out)
  );
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
  parameter int RST_CYCLES = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       tick,
  input logic       kick,
  input logic       reload,
  input logic       expire,
  input logic       act_reset,
  input logic [5:0] cnt,
  input logic [5:0] ivl_now,
  input logic [5:0] ivl_load,
  input logic       sys_rst,
  input logic       irq
);
  int run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= 0;
    else if (sys_rst) run_q <= run_q + 1;
    else              run_q <= 0;
  end

  assert_kick_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt == $past(ivl_now)));

  assert_stopped_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!tick && !expire));

  assert_reload_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt == $past(ivl_load)));

  assert_reset_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && act_reset) |=> sys_rst);

  assert_irq_action_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !act_reset) |=> irq);

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !kick) |=> irq);

  assert_kick_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !irq);

  assert_pulse_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RST_CYCLES);
endmodule

bind kwdt_top kwdt_checker #(.RST_CYCLES(RST_CYCLES)) u_kwdt_checker (
  .clk(clk), .rst_n(rst_n), .en(en_w), .tick(tick_w), .kick(kick_w),
  .reload(reload_w), .expire(expire_w), .act_reset(act_reset_w), .cnt(cnt_w),
  .ivl_now(ivl_now_w), .ivl_load(ivl_load_w), .sys_rst(sys_rst_out), .irq(irq_out)
);

// File: tb/test_kwdt_top.sv
`timescale 1ns/1ps
module test_kwdt_top;
  localparam int P  = 4;
  localparam int RC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr0 = 1'b0, wr1 = 1'b0;
  logic [31:0] rd0, rd1;
  logic        rst0, rst1, irq0, irq1;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  kwdt_top #(.VARIANT(0), .PRESCALE(P), .RST_CYCLES(RC)) i_kwdt_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr0), .bus_wdata(wdata),
    .bus_rdata(rd0), .sys_rst_out(rst0), .irq_out(irq0));

  kwdt_top #(.VARIANT(1), .PRESCALE(P), .RST_CYCLES(RC)) i_kwdt_top_v1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr1), .bus_wdata(wdata),
    .bus_rdata(rd1), .sys_rst_out(rst1), .irq_out(irq1));

  function automatic int exp_ticks(input int code);
    if (code == 0) return 1;
    if (code <= 6) return 2 * code;
    if (code >= 11) return 32;
    return 4 * code - 12;
  endfunction

  function automatic bit exp_reset(input int v, input logic [1:0] act);
    return (v == 0) ? act[1] : (act == 2'b01);
  endfunction

  function automatic logic [31:0] mode_word(input int v, input int code);
    return 32'(1 + (code << ((v == 0) ? 3 : 4)));
  endfunction

  function automatic logic [1:0] outs(input int v);
    return (v == 0) ? {rst0, irq0} : {rst1, irq1};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int v, input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d;
    if (v == 0) wr0 = 1'b1; else wr1 = 1'b1;
    @(negedge clk);
    wr0 = 1'b0; wr1 = 1'b0;
  endtask

  task automatic read_chk(input int v, input logic [1:0] a, input logic [31:0] exp, input string tag);
    addr = a; #1;
    chk(tag, (v == 0) ? rd0 : rd1, exp);
  endtask

  task automatic expect_fire(input int v, input int cyc, input bit rst_act, input string tag);
    repeat (cyc - 1) @(negedge clk);
    chk({tag, " quiet"}, 32'(outs(v)), 32'd0);
    @(negedge clk);
    chk({tag, " fire"}, 32'(outs(v)), rst_act ? 32'd2 : 32'd1);
  endtask

  task automatic kick_stop(input int v, input string tag);
    bus_write(v, 2'd0, 32'h0000_14AF);
    chk({tag, " kick clears irq R9"}, 32'(outs(v) & 2'b01), 32'd0);
    bus_write(v, 2'd1, 32'd0);
  endtask

  task automatic run_case(input int v, input int code, input logic [1:0] act, input string tag);
    bit r;
    r = exp_reset(v, act);
    bus_write(v, 2'd1, 32'd0);
    bus_write(v, 2'd2, {30'd0, act});
    bus_write(v, 2'd1, mode_word(v, code));
    expect_fire(v, exp_ticks(code) * P, r, tag);
    if (r) begin
      repeat (RC - 1) @(negedge clk);
      chk({tag, " pulse held R10"}, 32'(outs(v)), 32'd2);
      @(negedge clk);
      chk({tag, " pulse ends R10"}, 32'(outs(v)), 32'd0);
    end
    kick_stop(v, tag);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R11 reset outputs", {30'd0, rst0, irq0}, 32'd0);
    read_chk(0, 2'd1, 32'd0, "R11 mode after reset");
    read_chk(0, 2'd2, 32'd0, "R11 action after reset");
    @(negedge clk);
    bus_write(0, 2'd1, 32'h1234_5670);
    bus_write(0, 2'd2, 32'hCAFE_0004);
    read_chk(0, 2'd1, 32'h1234_5670, "R11 mode readback");
    read_chk(0, 2'd2, 32'hCAFE_0004, "R11 action readback");
    read_chk(0, 2'd0, 32'd0, "R11 kick reads zero");
    read_chk(0, 2'd3, 32'd0, "R11 spare reads zero");
    @(negedge clk);

    // interval table corners, variant 0
    run_case(0, 0, 2'b00, "R5 code0 irq");
    run_case(0, 11, 2'b10, "R5 R7 code11 reset");
    run_case(0, 14, 2'b00, "R5 code14 as code11");
    run_case(0, 7, 2'b01, "R7 bit1 clear gives irq");

    // periodic reset expiry
    bus_write(0, 2'd2, 32'd2);
    bus_write(0, 2'd1, mode_word(0, 2));
    expect_fire(0, 16, 1'b1, "R10 first");
    expect_fire(0, 16, 1'b1, "R10 second");
    kick_stop(0, "R10");

    // wrong key keeps original deadline
    bus_write(0, 2'd2, 32'd0);
    bus_write(0, 2'd1, mode_word(0, 3));
    repeat (9) @(negedge clk);
    bus_write(0, 2'd0, 32'h0000_14AE);
    expect_fire(0, 14, 1'b0, "R2 bad key");
    kick_stop(0, "R2");

    // correct key with junk upper bits restarts the interval
    bus_write(0, 2'd1, mode_word(0, 3));
    repeat (9) @(negedge clk);
    bus_write(0, 2'd0, 32'hFFFF_F4AF);
    expect_fire(0, 24, 1'b0, "R1 good kick");
    kick_stop(0, "R1");

    // interval change while enabled
    bus_write(0, 2'd1, mode_word(0, 5));
    repeat (9) @(negedge clk);
    bus_write(0, 2'd1, mode_word(0, 1));
    expect_fire(0, 8, 1'b0, "R6 code change");
    kick_stop(0, "R6");

    // stopped watchdog stays quiet; irq stays after stop
    bus_write(0, 2'd1, mode_word(0, 0));
    repeat (4) @(negedge clk);
    chk("R9 irq set", 32'(outs(0)), 32'd1);
    bus_write(0, 2'd1, 32'd0);
    repeat (150) @(negedge clk);
    chk("R3 R9 stopped quiet, irq kept", 32'(outs(0)), 32'd1);
    kick_stop(0, "R3");

    // variant 1 action encodings and field position
    for (int a = 0; a < 4; a++) run_case(1, 4, 2'(a), "R8 variant1 action");
    bus_write(1, 2'd2, 32'd0);
    bus_write(1, 2'd1, 32'h0000_0019);
    expect_fire(1, 8, 1'b0, "R4 field at bits 7:4");
    kick_stop(1, "R4");
    bus_write(0, 2'd2, 32'd0);
    bus_write(0, 2'd1, 32'h0000_0019);
    expect_fire(0, 24, 1'b0, "R4 field at bits 6:3");
    kick_stop(0, "R4");

    // random mix
    for (int i = 0; i < 24; i++) begin
      int v, code;
      logic [1:0] act;
      v = int'($urandom % 2);
      code = int'($urandom % 16);
      act = 2'($urandom % 4);
      run_case(v, code, act, "R5 R7 R8 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule